// File: doc/BRIEF.md
# Protected Channel Gate Latch with Inrush Blanking

This block holds the on/off state of a bank of low-side power channels and drives one gate-enable line per channel. A serial front end delivers a complete control word together with a one-cycle load strobe when its transfer closes. On that strobe every channel takes its new state at the same moment, and a blanking window of a fixed number of system clock cycles opens.

Each channel has a digital flag from its output comparator. The flag goes high when a channel that should be conducting fails to pull its output down into saturation. While the window is open and the chip-select level is high, these flags are ignored, so lamps and inductive loads can draw their inrush current. Once the window has closed, or at any time the chip-select level is low, a channel that is ON and flags a fault is switched OFF on its own. It then stays OFF until the next load. An asynchronous active-low reset forces every channel OFF.

Top module: `gate_hold_latch`

## Requirements
- R1: While `rstN` is low, every bit of `gateEn` is 0 without waiting for a clock edge, and no blanking window is open once reset is released.
- R2: A clock edge with `loadStb` high copies `ctrlWord` into `gateEn`. Bit i set to 1 means channel i ON. The load takes precedence over fault clearing at that same edge.
- R3: For the `BLANK_CYC` clock edges that follow a load edge, with `chipSelN` high, no fault flag changes `gateEn`.
- R4: From the edge `BLANK_CYC`+1 after the load onward, any channel that is ON with its `satFault` bit high at an edge is OFF after that edge.
- R5: A `satFault` bit on a channel that is OFF has no effect on that channel.
- R6: Clearing one channel leaves every other channel's `gateEn` bit unchanged.
- R7: A channel cleared by a fault stays OFF after the flag drops, until the next load. No bit of `gateEn` goes from 0 to 1 without a load.
- R8: A load that arrives while a window is open restarts the window at full length from that load.
- R9: While `chipSelN` is low, fault clearing is enabled even inside a blanking window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset, all channels OFF |
| ctrlWord | input | CH | New channel states, 1 = ON |
| loadStb | input | 1 | One-cycle strobe that latches `ctrlWord` and opens the blanking window |
| chipSelN | input | 1 | Chip-select level; low enables fault clearing regardless of the window |
| satFault | input | CH | Per-channel out-of-saturation flags, synchronous to `clk` |
| gateEn | output | CH | Per-channel gate enable, 1 = conducting |

## Verification
The bench probes the exact edge at which the blanking window lets go. A counter that is off by one would clear a faulty channel one edge early or hold it one edge too long. It also reloads in the middle of a window: a design that does not restart the timer would drop the channel six edges after the second load, not `BLANK_CYC`+1 edges after it. Further cases cover a fault on an OFF channel, which a careless clear-mask would turn into a spurious change, and a load arriving together with a fault. If clearing won over the load there, the fresh word would be lost. A low chip select during blanking must clear at once; a design that ignores it would keep a shorted channel on for the whole window.

// File: rtl/gate_latch_pkg.sv
`timescale 1ns/1ps
package gate_latch_pkg;

  // Strobes passed from the window control to the channel datapath.
  typedef struct packed {
    logic loadNow;    // take a new control word this edge
    logic unlatchOk;  // faulted ON channels may be cleared this edge
  } latchStb_t;

endpackage

// File: rtl/gate_latch_ctl.sv
`timescale 1ns/1ps
module gate_latch_ctl
  import gate_latch_pkg::*;
#(
  parameter int BLANK_CYC = 37500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadStb,
  input  logic      chipSelN,
  output latchStb_t stb
);

  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] WINDOW_INIT = CW'(BLANK_CYC);

  logic [CW-1:0] windowCnt;
  logic          windowOpen;

  // The count is reloaded by every load, so a second load restarts the window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      windowCnt <= '0;
    end else if (loadStb) begin
      windowCnt <= WINDOW_INIT;
    end else if (windowOpen) begin
      windowCnt <= windowCnt - CW'(1);
    end
  end

  assign windowOpen = (windowCnt != '0);

  always_comb begin
    stb.loadNow   = loadStb;
    stb.unlatchOk = !windowOpen || !chipSelN;
  end

endmodule

// File: rtl/gate_latch_dp.sv
`timescale 1ns/1ps
module gate_latch_dp
  import gate_latch_pkg::*;
#(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  latchStb_t     stb,
  input  logic [CH-1:0] ctrlWord,
  input  logic [CH-1:0] satFault,
  output logic [CH-1:0] gateEn
);

  logic [CH-1:0] chanQ;

  // One flop per channel. A load wins over a clear, and each channel
  // sees only its own fault flag.
  for (genvar ch = 0; ch < CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanQ[ch] <= 1'b0;
      end else if (stb.loadNow) begin
        chanQ[ch] <= ctrlWord[ch];
      end else if (stb.unlatchOk && satFault[ch] && chanQ[ch]) begin
        chanQ[ch] <= 1'b0;
      end
    end
  end

  assign gateEn = chanQ;

endmodule

// File: rtl/gate_hold_latch.sv
`timescale 1ns/1ps
module gate_hold_latch
  import gate_latch_pkg::*;
#(
  parameter int CH        = 8,
  parameter int BLANK_CYC = 37500
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CH-1:0] ctrlWord,
  input  logic          loadStb,
  input  logic          chipSelN,
  input  logic [CH-1:0] satFault,
  output logic [CH-1:0] gateEn
);

  latchStb_t stb;

  gate_latch_ctl #(.BLANK_CYC(BLANK_CYC)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .loadStb  (loadStb),
    .chipSelN (chipSelN),
    .stb      (stb)
  );

  gate_latch_dp #(.CH(CH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .ctrlWord (ctrlWord),
    .satFault (satFault),
    .gateEn   (gateEn)
  );

endmodule

// File: rtl/gate_hold_latch_chk.sv
`timescale 1ns/1ps
module gate_hold_latch_chk #(
  parameter int CH        = 8,
  parameter int BLANK_CYC = 37500
) (
  input logic          clk,
  input logic          rstN,
  input logic [CH-1:0] ctrlWord,
  input logic          loadStb,
  input logic          chipSelN,
  input logic [CH-1:0] satFault,
  input logic [CH-1:0] gateEn
);

  // The window is tracked here with a counter, not a long $past chain.
  int sinceLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sinceLoad <= 0;
    else if (loadStb)      sinceLoad <= BLANK_CYC;
    else if (sinceLoad > 0) sinceLoad <= sinceLoad - 1;
  end

  // R1
  reset_off_chk: assert property (@(posedge clk) !rstN |-> gateEn == '0);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> gateEn == $past(ctrlWord));

  // R3
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && sinceLoad != 0 && chipSelN) |=> $stable(gateEn));

  // R4
  unlatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && (sinceLoad == 0 || !chipSelN))
      |=> gateEn == ($past(gateEn) & ~$past(satFault)));

  // R7
  no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> (gateEn & ~$past(gateEn)) == '0);

  // R6
  clean_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> (($past(gateEn) & ~$past(satFault)) & ~gateEn) == '0);

endmodule

bind gate_hold_latch gate_hold_latch_chk #(.CH(CH), .BLANK_CYC(BLANK_CYC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ctrlWord (ctrlWord),
  .loadStb  (loadStb),
  .chipSelN (chipSelN),
  .satFault (satFault),
  .gateEn   (gateEn)
);

// File: tb/gate_hold_latch_bench.sv
`timescale 1ns/1ps
module gate_hold_latch_bench;

  localparam int CH    = 8;
  localparam int BLANK = 12;

  logic          clk = 1'b0;
  logic          rstN;
  logic [CH-1:0] ctrlWord;
  logic          loadStb;
  logic          chipSelN;
  logic [CH-1:0] satFault;
  logic [CH-1:0] gateEn;

  int    nChk  = 0;
  int    nFail = 0;
  bit    live  = 1'b0;
  string phase = "R1";

  always #2 clk = ~clk;

  gate_hold_latch #(.CH(CH), .BLANK_CYC(BLANK)) u_gate_hold_latch (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWord (ctrlWord),
    .loadStb  (loadStb),
    .chipSelN (chipSelN),
    .satFault (satFault),
    .gateEn   (gateEn)
  );

  // Behavioural reference: channel word plus a cycles-left integer.
  logic [CH-1:0] mGate;
  int            mLeft;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mGate <= '0;
      mLeft <= 0;
    end else if (loadStb) begin
      mGate <= ctrlWord;
      mLeft <= BLANK;
    end else begin
      if (mLeft == 0 || !chipSelN) mGate <= mGate & ~satFault;
      if (mLeft > 0) mLeft <= mLeft - 1;
    end
  end

  task automatic check(string tag, logic [CH-1:0] act, logic [CH-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) check(phase, gateEn, mGate);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    nChk++;
    $display("FAIL R2 watchdog act=running exp=done");
    summary();
  end

  initial begin
    rstN = 1'b0; ctrlWord = '0; loadStb = 1'b0; chipSelN = 1'b1; satFault = '0;
    step(1);
    check("R1 reset", gateEn, 8'h00);
    rstN = 1'b1;
    live = 1'b1;
    step(2);

    // R2 load, then R3 blanking, R4 clear, R5 off-channel fault, R6 independence
    phase = "R2";
    ctrlWord = 8'hA5; loadStb = 1'b1;
    step(1);
    check("R2 load", gateEn, 8'hA5);
    loadStb = 1'b0; satFault = 8'h03; phase = "R3";
    step(BLANK);
    check("R3 blank hold", gateEn, 8'hA5);
    phase = "R4";
    step(1);
    check("R4 R5 R6 clear bit0 only", gateEn, 8'hA4);
    satFault = '0; phase = "R7";
    step(5);
    check("R7 stays off", gateEn, 8'hA4);

    // R8 reload inside window restarts it
    phase = "R8";
    ctrlWord = 8'hFF; loadStb = 1'b1;
    step(1);
    loadStb = 1'b0; satFault = 8'h10;
    step(6);
    loadStb = 1'b1;
    step(1);
    loadStb = 1'b0;
    step(BLANK);
    check("R8 window restarted", gateEn, 8'hFF);
    step(1);
    check("R8 clear after restart", gateEn, 8'hEF);
    satFault = '0;
    step(BLANK + 2);

    // R9 chip select low during blanking
    phase = "R9";
    ctrlWord = 8'h0F; loadStb = 1'b1;
    step(1);
    loadStb = 1'b0; satFault = 8'h01;
    step(3);
    check("R3 blank before select", gateEn, 8'h0F);
    chipSelN = 1'b0;
    step(1);
    check("R9 select low clears", gateEn, 8'h0E);
    chipSelN = 1'b1; satFault = '0;
    step(BLANK + 2);

    // R2 load wins over a same-edge clear
    phase = "R2";
    satFault = 8'hFF; chipSelN = 1'b0; ctrlWord = 8'hFF; loadStb = 1'b1;
    step(1);
    check("R2 load priority", gateEn, 8'hFF);
    loadStb = 1'b0;
    step(1);
    check("R9 clears all", gateEn, 8'h00);
    satFault = '0; chipSelN = 1'b1;
    step(3);
    check("R7 no rise", gateEn, 8'h00);

    // R1 asynchronous reset mid-cycle
    phase = "R1";
    ctrlWord = 8'h3C; loadStb = 1'b1;
    step(1);
    loadStb = 1'b0;
    check("R2 load 3C", gateEn, 8'h3C);
    #1 rstN = 1'b0;
    #0.5 check("R1 async clear", gateEn, 8'h00);
    step(1);
    rstN = 1'b1;
    satFault = 8'hFF;
    step(2);
    check("R1 held off", gateEn, 8'h00);
    satFault = '0;
    step(2);
    live = 1'b0;
    summary();
  end

endmodule